// File: doc/BRIEF.md
# Compare-Driven Waveform Timer

This block is a free-running up-counter with a set of compare channels (three by default) that turn counter events into waveform outputs. The counter advances only on cycles where an external clock-select stage raises the `tick` input. Software loads the count, the compare values and a capture/period register through simple write strobes. The static configuration inputs choose one of three operating modes, the source of the period limit (TOP), and each channel's output action.

In free-running mode the counter wraps from all-ones to zero and raises the overflow flag. In clear-on-match mode the counter returns to zero after reaching TOP. Each channel output can then toggle, set or clear when its compare value matches. In fast PWM mode the counter runs from zero to TOP and starts again, so TOP fixes the period and each compare value fixes a duty cycle. Every channel has a sticky match flag, and the counter has an overflow flag. Software clears any flag by pulsing a one on the matching `flag_clr` bit.

Top module: `cmp_timer`

## Requirements
- R1: After reset, `count` is 0, every flag is 0 and every `wave_out` bit is 0.
- R2: With `tick` low and no counter write, `count` holds its value. With `tick` high it advances by one per cycle. A counter write (`cnt_we`) loads `cnt_wdata` and takes priority over a tick in the same cycle.
- R3: With `op_mode` = 0 (free-running), the count wraps from 0xFFFF to 0x0000, that wrap sets `ovf_flag`, and every `wave_out` bit stays 0.
- R4: With `op_mode` = 1 (clear-on-match), a tick taken while `count` equals TOP loads 0 instead of TOP+1. TOP is the capture register when `top_sel` = 3 and compare register 0 (channel A) otherwise.
- R5: In clear-on-match mode, a channel whose `chan_mode` field (bits 2i+1:2i) is 01 toggles its output on a match. A field of 11 sets the output on a match and a field of 10 clears it.
- R6: With `op_mode` = 2 (fast PWM), the count restarts at 0 after TOP. TOP is 0x00FF, 0x01FF or 0x03FF for `top_sel` 0, 1 or 2, the capture register for 3, and compare register 0 for 4 to 7.
- R7: In fast PWM mode, channel field 10 sets the output at TOP and clears it on a match, so the output is high while count ≤ compare value. Field 11 does the reverse. When a match and TOP occur on the same tick, the TOP action wins.
- R8: A tick taken while `count` equals a channel's compare register sets that channel's `match_flag` bit. A count that is only written, with no tick, sets nothing.
- R9: A one on `flag_clr` bit i (i < NCH) clears `match_flag[i]`, and bit NCH clears `ovf_flag`. If a set event and a clear arrive in the same cycle, the set wins.
- R10: A channel with field 00 drives `wave_out` 0 in every mode.
- R11: With `ovf_at_top` high in modes 1 and 2, a tick taken at TOP also sets `ovf_flag`. With it low, only the 0xFFFF wrap sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the clock-select stage |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| cmp_we | input | NCH | Per-channel compare write strobes |
| cmp_wdata | input | W | Compare write value |
| cap_we | input | 1 | Capture/period register write strobe |
| cap_wdata | input | W | Capture/period write value |
| op_mode | input | 2 | 0 free-running, 1 clear-on-match, 2 fast PWM, 3 treated as 0 |
| top_sel | input | 3 | TOP source select |
| chan_mode | input | 2*NCH | Per-channel output action fields |
| ovf_at_top | input | 1 | Also flag overflow at TOP in modes 1 and 2 |
| flag_clr | input | NCH+1 | Write-one-to-clear for match flags and (MSB) overflow flag |
| count | output | W | Current counter value |
| wave_out | output | NCH | Channel waveform outputs |
| match_flag | output | NCH | Sticky compare-match flags |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong count shows at the `count` port on the very next cycle. It also moves every later match and TOP event, so the bench compares the count after each tick with the value worked out from the previous sample. A wrong internal output state, such as a missed toggle or a lost TOP set, shows on `wave_out` after the edge that should have changed it. It then stays wrong for a whole period, so per-cycle checks against a duty rule or a toggle parity catch it within one TOP period. Flag errors are sticky, so one missed set or a wrong clear stays visible until the next explicit clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] OP_FREE = 2'd0;
  localparam logic [1:0] OP_CTC  = 2'd1;
  localparam logic [1:0] OP_PWM  = 2'd2;

  localparam logic [1:0] CH_OFF = 2'd0;
  localparam logic [1:0] CH_TGL = 2'd1;
  localparam logic [1:0] CH_LO  = 2'd2;
  localparam logic [1:0] CH_HI  = 2'd3;

  // fixed period limits: 8, 9 or 10 bits of ones
  function automatic logic [31:0] fixed_top(input logic [1:0] sel);
    return (32'd256 << sel) - 32'd1;
  endfunction

  function automatic logic drives_pins(input logic [1:0] op);
    return (op == OP_CTC) || (op == OP_PWM);
  endfunction

  // next internal output state of one channel
  function automatic logic next_wave(input logic [1:0] op, input logic [1:0] cm,
                                     input logic hit, input logic at_top,
                                     input logic cur);
    logic r;
    r = cur;
    if (op == OP_PWM && at_top && cm == CH_LO)      r = 1'b1;
    else if (op == OP_PWM && at_top && cm == CH_HI) r = 1'b0;
    else if (drives_pins(op) && hit) begin
      case (cm)
        CH_TGL:  r = ~cur;
        CH_LO:   r = 1'b0;
        CH_HI:   r = 1'b1;
        default: r = cur;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (step)    count <= restart ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] count,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   cm,
  input  logic [1:0]   op,
  input  logic         top_ev,
  input  logic         clr,
  output logic [W-1:0] cmp_q,
  output logic         match_ev,
  output logic         flag,
  output logic         wave
);
  import tmr_pkg::*;

  logic wave_q;

  assign match_ev = step && (count == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag   <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (wr) cmp_q <= wdata;
      if (match_ev)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
      wave_q <= next_wave(op, cm, match_ev, top_ev, wave_q);
    end
  end

  assign wave = (cm != CH_OFF) && drives_pins(op) && wave_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           cnt_we,
  input  logic [W-1:0]   cnt_wdata,
  input  logic [NCH-1:0] cmp_we,
  input  logic [W-1:0]   cmp_wdata,
  input  logic           cap_we,
  input  logic [W-1:0]   cap_wdata,
  input  logic [1:0]     op_mode,
  input  logic [2:0]     top_sel,
  input  logic [2*NCH-1:0] chan_mode,
  input  logic           ovf_at_top,
  input  logic [NCH:0]   flag_clr,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] wave_out,
  output logic [NCH-1:0] match_flag,
  output logic           ovf_flag
);
  import tmr_pkg::*;

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0]   cap_q;
  logic [W-1:0]   top_val;
  logic [W-1:0]   cmp_arr [NCH];
  logic [NCH-1:0] match_ev;
  logic           step;
  logic           restart;
  logic           ovf_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_we) cap_q <= cap_wdata;
  end

  always_comb begin
    case (op_mode)
      OP_CTC:  top_val = (top_sel == 3'd3) ? cap_q : cmp_arr[0];
      OP_PWM: begin
        case (top_sel)
          3'd0, 3'd1, 3'd2: top_val = W'(fixed_top(top_sel[1:0]));
          3'd3:             top_val = cap_q;
          default:          top_val = cmp_arr[0];
        endcase
      end
      default: top_val = ALL_ONES;
    endcase
  end

  assign step    = tick && !cnt_we;
  assign restart = step && drives_pins(op_mode) && (count == top_val);
  assign ovf_ev  = step && ((count == ALL_ONES) || (ovf_at_top && restart));

  tmr_count #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (cnt_we),
    .load_val (cnt_wdata),
    .restart  (restart),
    .count    (count)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .count    (count),
      .wr       (cmp_we[g]),
      .wdata    (cmp_wdata),
      .cm       (chan_mode[2*g +: 2]),
      .op       (op_mode),
      .top_ev   (restart),
      .clr      (flag_clr[g]),
      .cmp_q    (cmp_arr[g]),
      .match_ev (match_ev[g]),
      .flag     (match_flag[g]),
      .wave     (wave_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ovf_flag <= 1'b0;
    else if (ovf_ev)        ovf_flag <= 1'b1;
    else if (flag_clr[NCH]) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           cnt_we,
  input logic [W-1:0]   cnt_wdata,
  input logic [1:0]     op_mode,
  input logic [2*NCH-1:0] chan_mode,
  input logic [NCH:0]   flag_clr,
  input logic [W-1:0]   count,
  input logic [NCH-1:0] wave_out,
  input logic [NCH-1:0] match_flag,
  input logic           ovf_flag,
  input logic [NCH-1:0] match_ev,
  input logic           ovf_ev,
  input logic           restart
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));
  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
  // R4
  top_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));
  // R3
  free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'd0) |-> (wave_out == '0));
  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag);
  // R9
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[NCH] && !ovf_ev) |=> !ovf_flag);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_mode[2*g +: 2] == 2'b00) |-> !wave_out[g]);
    // R8
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev[g] |=> match_flag[g]);
    // R9
    match_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[g] && !match_ev[g]) |=> !match_flag[g]);
  end
endmodule

bind cmp_timer cmp_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .cnt_we     (cnt_we),
  .cnt_wdata  (cnt_wdata),
  .op_mode    (op_mode),
  .chan_mode  (chan_mode),
  .flag_clr   (flag_clr),
  .count      (count),
  .wave_out   (wave_out),
  .match_flag (match_flag),
  .ovf_flag   (ovf_flag),
  .match_ev   (match_ev),
  .ovf_ev     (ovf_ev),
  .restart    (restart)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n, tick, cnt_we, cap_we, ovf_at_top;
  logic [W-1:0] cnt_wdata, cmp_wdata, cap_wdata;
  logic [NCH-1:0] cmp_we;
  logic [1:0] op_mode;
  logic [2:0] top_sel;
  logic [2*NCH-1:0] chan_mode;
  logic [NCH:0] flag_clr;
  logic [W-1:0] count;
  logic [NCH-1:0] wave_out, match_flag;
  logic ovf_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_timer #(.W(W), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cap_we(cap_we), .cap_wdata(cap_wdata),
    .op_mode(op_mode), .top_sel(top_sel), .chan_mode(chan_mode),
    .ovf_at_top(ovf_at_top), .flag_clr(flag_clr), .count(count),
    .wave_out(wave_out), .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; cnt_we = 0; cap_we = 0; ovf_at_top = 0;
    cnt_wdata = '0; cmp_wdata = '0; cap_wdata = '0; cmp_we = '0;
    op_mode = 2'd0; top_sel = 3'd0; chan_mode = '0; flag_clr = '0;
    cyc(); cyc();
    rst_n = 1;
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_we = 1; cnt_wdata = v; cyc(); cnt_we = 0;
  endtask

  task automatic wr_cmp(input int i, input logic [W-1:0] v);
    cmp_we = NCH'(1 << i); cmp_wdata = v; cyc(); cmp_we = '0;
  endtask

  task automatic wr_cap(input logic [W-1:0] v);
    cap_we = 1; cap_wdata = v; cyc(); cap_we = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pc;
    logic [W-1:0] cv [NCH];
    logic [NCH-1:0] expw;

    // R1 reset state
    do_reset();
    check("R1 count", count, 0);
    check("R1 flags", {ovf_flag, match_flag}, 0);
    check("R1 wave", wave_out, 0);

    // R2 hold without tick, advance with tick, write priority
    repeat (5) cyc();
    check("R2 hold", count, 0);
    tick = 1;
    repeat (5) cyc();
    check("R2 advance", count, 5);
    cnt_we = 1; cnt_wdata = 16'h1234; cyc(); cnt_we = 0;
    check("R2 write wins", count, 16'h1234);
    cyc();
    check("R2 after write", count, 16'h1235);
    tick = 0;

    // R3 free-running wrap and quiet outputs
    do_reset();
    chan_mode = 6'b010101;
    wr_cmp(0, 16'hFFFE);
    wr_cnt(16'hFFFD);
    tick = 1;
    cyc(); cyc();
    check("R3 at max", count, 16'hFFFF);
    check("R3 no ovf yet", ovf_flag, 0);
    cyc();
    check("R3 wrap", count, 0);
    check("R3 ovf set", ovf_flag, 1);
    check("R3 outputs quiet", wave_out, 0);
    tick = 0;
    flag_clr = 4'b1000; cyc(); flag_clr = '0;
    check("R9 ovf cleared", ovf_flag, 0);

    // R4 clear-on-match with TOP from compare A, then capture
    do_reset();
    op_mode = 2'd1; top_sel = 3'd4;
    wr_cmp(0, 16'd5);
    tick = 1;
    for (int k = 0; k < 15; k++) begin
      pc = count; cyc();
      check("R4 cmpA top", count, (pc == 5) ? 0 : pc + 1);
    end
    check("R11 no ovf when off", ovf_flag, 0);
    ovf_at_top = 1;
    repeat (6) cyc();
    check("R11 ovf at top", ovf_flag, 1);
    tick = 0; ovf_at_top = 0;
    top_sel = 3'd3;
    wr_cap(16'd3);
    tick = 1;
    for (int k = 0; k < 10; k++) begin
      pc = count; cyc();
      check("R4 capture top", count, (pc == 3) ? 0 : pc + 1);
    end
    tick = 0;

    // R5 toggle then set/clear; R10 disconnected channel
    do_reset();
    op_mode = 2'd1; top_sel = 3'd3;
    wr_cap(16'd9);
    cv[0] = 2; cv[1] = 5; cv[2] = 9;
    for (int j = 0; j < NCH; j++) wr_cmp(j, cv[j]);
    chan_mode = 6'b010101;
    expw = '0;
    tick = 1;
    for (int k = 0; k < 40; k++) begin
      pc = count; cyc();
      for (int j = 0; j < NCH; j++) if (pc == cv[j]) expw[j] = ~expw[j];
      check("R4 ctc count", count, (pc == 9) ? 0 : pc + 1);
      check("R5 toggle", wave_out, expw);
    end
    chan_mode = 6'b001011;
    for (int k = 0; k < 30; k++) begin
      pc = count; cyc();
      if (pc == cv[0]) expw[0] = 1'b1;
      if (pc == cv[1]) expw[1] = 1'b0;
      expw[2] = 1'b0;
      check("R5 set/clear", wave_out[1:0], expw[1:0]);
      check("R10 off channel", wave_out[2], 0);
    end
    tick = 0;

    // R7 fast PWM duty sweep over every compare value, capture TOP
    do_reset();
    op_mode = 2'd2; top_sel = 3'd3;
    wr_cap(16'd7);
    chan_mode = 6'b111000;
    for (int c = 0; c < 8; c++) begin
      tick = 0;
      wr_cmp(1, W'(c)); wr_cmp(2, W'(c));
      wr_cnt(0);
      tick = 1;
      for (int k = 0; k < 24; k++) begin
        cyc();
        if (k >= 8) begin
          check("R7 low-on-match", wave_out[1], (count <= W'(c)) ? 1 : 0);
          check("R7 high-on-match", wave_out[2], (count <= W'(c)) ? 0 : 1);
          check("R10 pwm off", wave_out[0], 0);
        end
      end
      check("R8 pwm flag", match_flag[2:1], 2'b11);
    end
    tick = 0;

    // R6 fixed and compare-A TOP in fast PWM
    do_reset();
    op_mode = 2'd2;
    for (int s = 0; s < 3; s++) begin
      top_sel = 3'(s);
      wr_cnt(W'((256 << s) - 2));
      tick = 1; cyc();
      check("R6 fixed top reached", count, (256 << s) - 1);
      cyc();
      check("R6 fixed top restart", count, 0);
      tick = 0;
    end
    top_sel = 3'd4;
    wr_cmp(0, 16'h0020);
    wr_cnt(16'h001F);
    tick = 1; cyc(); cyc();
    check("R6 cmpA top restart", count, 0);
    tick = 0;

    // R8 match flags need a tick; R9 clear and set-wins
    do_reset();
    wr_cmp(0, 16'd3);
    wr_cmp(1, 16'd9);
    wr_cmp(2, 16'd9);
    wr_cnt(16'd3);
    cyc();
    check("R8 no tick no flag", match_flag, 0);
    tick = 1; cyc(); tick = 0;
    check("R8 flag A only", match_flag, 3'b001);
    flag_clr = 4'b0001; cyc(); flag_clr = '0;
    check("R9 match cleared", match_flag, 0);
    wr_cnt(16'd3);
    tick = 1; flag_clr = 4'b0001; cyc(); tick = 0; flag_clr = '0;
    check("R9 set wins", match_flag, 3'b001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule